// File: doc/BRIEF.md
# Daisy-Chained Peripheral Configuration Responder

This block is the bus-side command handler of one peripheral that shares a strobe-timed nibble bus with other peripherals. A requester sends a command nibble, flagged as such, and may follow it with data strobes. The block decodes the command and decides whether this device answers it. The decision depends on whether the device is configured and on the level of its daisy-chain input. The block keeps a configured flag and a 20-bit base address, and it passes the chain on to the next device once it is itself configured. This means that only the first unconfigured device in a chain can take a configuration.

A configure sequence is one command strobe followed by five data strobes, least significant nibble first. An unconfigure sequence uses the same layout and carries the address to release. An identify command makes an unconfigured device at the head of the chain present its fixed ID, one nibble per data strobe. A poll command makes a configured device drive its own bit of a four-bit response nibble. The reset, shutdown and device-specific commands produce single-cycle pulses or a standby flag. No-op codes and unused codes make the device ignore data strobes until the next command is loaded.

Top module: `chain_cfg_responder`

## Requirements
- R1: After reset the device is unconfigured, base_addr is 0, and chain_out, resp_en, resp_nib, local_rst, dev_go and sleep are all 0.
- R2: Command code 1 (configure) is taken only when the device is unconfigured and chain_in is high. The next five data strobes carry the address least significant nibble first. configured rises and base_addr takes the address in the cycle after the fifth data strobe.
- R3: A configured device ignores configure (code 1) and identify (code 3). It gives no response, and base_addr and configured do not change.
- R4: Command code 2 (unconfigure) on a configured device is followed by five address nibbles, least significant first. If they equal base_addr, the device becomes unconfigured and base_addr returns to 0. On a mismatch the device stays configured.
- R5: After an unconfigure the device again answers configure and identify.
- R6: chain_out is 0 while the device is unconfigured and equals chain_in while it is configured.
- R7: Identify (code 3) is taken only when the device is unconfigured and chain_in is high. resp_en is then 1 and resp_nib is nibble k of DEV_ID (bits 4k+3..4k) until the k-th following data strobe, for k = 0 to 4. Counting starts at 0 and ends after the fifth strobe.
- R8: Poll (code 4) on a configured device drives resp_en to 1 until the next strobe. resp_nib has bit POLL_BIT equal to svc_req and all other bits 0. An unconfigured device gives no poll response. When resp_en is 0, resp_nib is 0.
- R9: Bus reset (code 5) gives a one-cycle local_rst pulse in the cycle after its strobe. It leaves the device unconfigured with base_addr 0 and abandons any sequence in progress.
- R10: Device command (code 7) gives a one-cycle dev_go pulse in the cycle after its strobe, only if the device is configured and dev_sel is high.
- R11: Shutdown (code 6) sets sleep from the cycle after its strobe. Sleep stays set until the next command load of any other code.
- R12: No-op (code 0), the reserved codes 8 and 9, and codes 10 to 15 make all data strobes have no effect until the next command. A new command in the middle of a sequence abandons that sequence. A cycle with bus_strobe low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_strobe | input | 1 | A bus transfer takes place in this cycle |
| bus_cmd | input | 1 | The transfer is a command load (otherwise a data strobe) |
| bus_nib | input | 4 | Command code or data nibble |
| chain_in | input | 1 | Daisy-chain input from the previous device |
| dev_sel | input | 1 | The local data pointer addresses this device |
| svc_req | input | 1 | This device wants service |
| configured | output | 1 | Device holds a configuration |
| base_addr | output | 20 | Captured base address |
| chain_out | output | 1 | Daisy-chain output to the next device |
| resp_en | output | 1 | A response nibble is being driven |
| resp_nib | output | 4 | Response nibble (ID nibble or poll bit) |
| local_rst | output | 1 | One-cycle local reset pulse |
| dev_go | output | 1 | One-cycle device-specific command pulse |
| sleep | output | 1 | Standby requested by shutdown |

## Verification
The bound checker watches several rules on every cycle:
- the chain output stays low while the device is unconfigured;
- configuration and base address never move in a cycle without a strobe, and configured only rises after a data strobe;
- a bus reset always clears the configuration and pulses the local reset;
- dev_go appears only after a selected device command on a configured device;
- a configured device leaves its address alone and stays silent when a configure or identify arrives;
- shutdown raises sleep.

Some behaviour can only be shown by the bench's scenarios. These cover the exact nibble order of the captured address and of the ID response, and matching versus mismatching unconfigure addresses. They also cover sequences abandoned by a new command, data strobes ignored after no-op and reserved codes, and reconfiguration after release.

// File: rtl/chain_cfg_pkg.sv
package chain_cfg_pkg;

  localparam logic [3:0] CMD_NOP   = 4'd0;
  localparam logic [3:0] CMD_CFG   = 4'd1;
  localparam logic [3:0] CMD_UNCFG = 4'd2;
  localparam logic [3:0] CMD_ID    = 4'd3;
  localparam logic [3:0] CMD_POLL  = 4'd4;
  localparam logic [3:0] CMD_RESET = 4'd5;
  localparam logic [3:0] CMD_SHUT  = 4'd6;
  localparam logic [3:0] CMD_DEV   = 4'd7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG,
    ST_UNC,
    ST_ID,
    ST_POLL
  } state_t;

  typedef enum logic [2:0] {
    OP_IGNORE,
    OP_CFG,
    OP_UNC,
    OP_ID,
    OP_POLL,
    OP_RST,
    OP_SHUT,
    OP_DEV
  } op_t;

endpackage

// File: rtl/chain_cfg_decode.sv
module chain_cfg_decode
  import chain_cfg_pkg::*;
(
  input  logic [3:0] code,
  input  logic       is_cfg,
  input  logic       chain_in,
  input  logic       dev_sel,
  output op_t        op
);

  logic head_free;

  assign head_free = !is_cfg && chain_in;

  always_comb begin
    op = OP_IGNORE;
    case (code)
      CMD_CFG:   if (head_free)          op = OP_CFG;
      CMD_UNCFG: if (is_cfg)             op = OP_UNC;
      CMD_ID:    if (head_free)          op = OP_ID;
      CMD_POLL:  if (is_cfg)             op = OP_POLL;
      CMD_RESET:                         op = OP_RST;
      CMD_SHUT:                          op = OP_SHUT;
      CMD_DEV:   if (is_cfg && dev_sel)  op = OP_DEV;
      default:                           op = OP_IGNORE;
    endcase
  end

endmodule

// File: rtl/chain_cfg_collect.sv
module chain_cfg_collect #(
  parameter int ADDR_NIBS = 5,
  localparam int AW = 4 * ADDR_NIBS,
  localparam int SW = AW - 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic [3:0]    nib,
  output logic [AW-1:0] word
);

  logic [SW-1:0] sh_q;
  logic [SW-1:0] sh_d;

  generate
    if (SW > 4) begin : g_wide
      assign sh_d = {nib, sh_q[SW-1:4]};
    end else begin : g_narrow
      assign sh_d = nib;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (shift_en) begin
      sh_q <= sh_d;
    end
  end

  assign word = {nib, sh_q};

endmodule

// File: rtl/chain_cfg_respond.sv
module chain_cfg_respond
  import chain_cfg_pkg::*;
#(
  parameter int ADDR_NIBS = 5,
  parameter logic [4*ADDR_NIBS-1:0] DEV_ID = '0,
  parameter int POLL_BIT = 0,
  localparam int CW = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1
) (
  input  state_t        st,
  input  logic [CW-1:0] cnt,
  input  logic          svc_req,
  output logic          resp_en,
  output logic [3:0]    resp_nib
);

  logic [3:0] id_nibs [ADDR_NIBS];
  logic [3:0] poll_word;

  genvar gi;
  generate
    for (gi = 0; gi < ADDR_NIBS; gi++) begin : g_id
      assign id_nibs[gi] = DEV_ID[4*gi +: 4];
    end
    for (gi = 0; gi < 4; gi++) begin : g_poll
      assign poll_word[gi] = (gi == POLL_BIT) ? svc_req : 1'b0;
    end
  endgenerate

  always_comb begin
    resp_en  = 1'b0;
    resp_nib = 4'd0;
    case (st)
      ST_ID: begin
        resp_en  = 1'b1;
        resp_nib = id_nibs[cnt];
      end
      ST_POLL: begin
        resp_en  = 1'b1;
        resp_nib = poll_word;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/chain_cfg_responder.sv
module chain_cfg_responder
  import chain_cfg_pkg::*;
#(
  parameter int ADDR_NIBS = 5,
  parameter logic [4*ADDR_NIBS-1:0] DEV_ID = 20'h4B7E2,
  parameter int POLL_BIT = 2,
  localparam int AW = 4 * ADDR_NIBS,
  localparam int CW = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_strobe,
  input  logic          bus_cmd,
  input  logic [3:0]    bus_nib,
  input  logic          chain_in,
  input  logic          dev_sel,
  input  logic          svc_req,
  output logic          configured,
  output logic [AW-1:0] base_addr,
  output logic          chain_out,
  output logic          resp_en,
  output logic [3:0]    resp_nib,
  output logic          local_rst,
  output logic          dev_go,
  output logic          sleep
);

  localparam logic [CW-1:0] LAST = CW'(ADDR_NIBS - 1);

  state_t        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cfg_q, cfg_d;
  logic [AW-1:0] base_q, base_d;
  logic          sleep_q, sleep_d;
  logic          lrst_q, lrst_d;
  logic          dgo_q, dgo_d;
  op_t           op;
  logic [AW-1:0] word;
  logic          data_stb;
  logic          shift_en;
  logic          at_last;

  assign data_stb = bus_strobe && !bus_cmd;
  assign shift_en = data_stb && ((st_q == ST_CFG) || (st_q == ST_UNC));
  assign at_last  = (cnt_q == LAST);

  chain_cfg_decode u_decode (
    .code     (bus_nib),
    .is_cfg   (cfg_q),
    .chain_in (chain_in),
    .dev_sel  (dev_sel),
    .op       (op)
  );

  chain_cfg_collect #(.ADDR_NIBS(ADDR_NIBS)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .nib      (bus_nib),
    .word     (word)
  );

  chain_cfg_respond #(
    .ADDR_NIBS (ADDR_NIBS),
    .DEV_ID    (DEV_ID),
    .POLL_BIT  (POLL_BIT)
  ) u_respond (
    .st       (st_q),
    .cnt      (cnt_q),
    .svc_req  (svc_req),
    .resp_en  (resp_en),
    .resp_nib (resp_nib)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cfg_d   = cfg_q;
    base_d  = base_q;
    sleep_d = sleep_q;
    lrst_d  = 1'b0;
    dgo_d   = 1'b0;
    if (bus_strobe && bus_cmd) begin
      st_d    = ST_IDLE;
      cnt_d   = '0;
      sleep_d = 1'b0;
      case (op)
        OP_CFG:  st_d = ST_CFG;
        OP_UNC:  st_d = ST_UNC;
        OP_ID:   st_d = ST_ID;
        OP_POLL: st_d = ST_POLL;
        OP_RST: begin
          cfg_d  = 1'b0;
          base_d = '0;
          lrst_d = 1'b1;
        end
        OP_SHUT: sleep_d = 1'b1;
        OP_DEV:  dgo_d   = 1'b1;
        default: ;
      endcase
    end else if (data_stb) begin
      case (st_q)
        ST_CFG: begin
          if (at_last) begin
            cfg_d  = 1'b1;
            base_d = word;
            st_d   = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_UNC: begin
          if (at_last) begin
            if (word == base_q) begin
              cfg_d  = 1'b0;
              base_d = '0;
            end
            st_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_ID: begin
          if (at_last) begin
            st_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_POLL: st_d = ST_IDLE;
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      cfg_q   <= 1'b0;
      base_q  <= '0;
      sleep_q <= 1'b0;
      lrst_q  <= 1'b0;
      dgo_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      cfg_q   <= cfg_d;
      base_q  <= base_d;
      sleep_q <= sleep_d;
      lrst_q  <= lrst_d;
      dgo_q   <= dgo_d;
    end
  end

  assign configured = cfg_q;
  assign base_addr  = base_q;
  assign chain_out  = cfg_q && chain_in;
  assign local_rst  = lrst_q;
  assign dev_go     = dgo_q;
  assign sleep      = sleep_q;

endmodule

// File: rtl/chain_cfg_responder_chk.sv
module chain_cfg_responder_chk
  import chain_cfg_pkg::*;
#(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_strobe,
  input logic          bus_cmd,
  input logic [3:0]    bus_nib,
  input logic          chain_in,
  input logic          dev_sel,
  input logic          configured,
  input logic [AW-1:0] base_addr,
  input logic          chain_out,
  input logic          resp_en,
  input logic          local_rst,
  input logic          dev_go,
  input logic          sleep
);

  a_r6_chain_low_unconf: assert property (@(posedge clk) disable iff (!rst_n)
    !configured |-> !chain_out);

  a_r6_chain_needs_in: assert property (@(posedge clk) disable iff (!rst_n)
    chain_out |-> chain_in);

  a_r2_cfg_rise_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(configured) |-> $past(bus_strobe && !bus_cmd));

  a_r12_no_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_strobe) |-> ($stable(configured) && $stable(base_addr)));

  a_r3_cfg_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_strobe && bus_cmd && configured && ((bus_nib == CMD_CFG) || (bus_nib == CMD_ID)))
      |-> (!resp_en && configured && $stable(base_addr)));

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_strobe && bus_cmd && (bus_nib == CMD_RESET))
      |-> (local_rst && !configured && (base_addr == '0)));

  a_r10_dev_go_gated: assert property (@(posedge clk) disable iff (!rst_n)
    dev_go |-> $past(bus_strobe && bus_cmd && configured && dev_sel && (bus_nib == CMD_DEV)));

  a_r11_shut_sets_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_strobe && bus_cmd && (bus_nib == CMD_SHUT)) |-> sleep);

endmodule

bind chain_cfg_responder chain_cfg_responder_chk #(.AW(AW)) u_chk (.*);

// File: tb/chain_cfg_responder_bench.sv
`timescale 1ns/1ps
module chain_cfg_responder_bench;

  localparam logic [19:0] ID_VAL = 20'h4B7E2;
  localparam int PBIT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_strobe = 1'b0;
  logic        bus_cmd = 1'b0;
  logic [3:0]  bus_nib = 4'd0;
  logic        chain_in = 1'b0;
  logic        dev_sel = 1'b0;
  logic        svc_req = 1'b0;
  logic        configured;
  logic [19:0] base_addr;
  logic        chain_out;
  logic        resp_en;
  logic [3:0]  resp_nib;
  logic        local_rst;
  logic        dev_go;
  logic        sleep;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chain_cfg_responder #(.ADDR_NIBS(5), .DEV_ID(ID_VAL), .POLL_BIT(PBIT)) u_chain_cfg_responder (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_cmd(bus_cmd),
    .bus_nib(bus_nib), .chain_in(chain_in), .dev_sel(dev_sel), .svc_req(svc_req),
    .configured(configured), .base_addr(base_addr), .chain_out(chain_out),
    .resp_en(resp_en), .resp_nib(resp_nib), .local_rst(local_rst),
    .dev_go(dev_go), .sleep(sleep)
  );

  // behavioural reference: phase 0 idle, 1 take address, 2 release address, 3 show ID, 4 poll
  int         m_phase;
  int         m_k;
  bit         m_cfg;
  int         m_base;
  bit         m_sleep;
  bit         m_lrst;
  bit         m_dgo;
  logic [3:0] q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_k = 0; m_cfg = 0; m_base = 0;
      m_sleep = 0; m_lrst = 0; m_dgo = 0; q.delete();
    end else begin
      m_lrst = 0;
      m_dgo = 0;
      if (bus_strobe && bus_cmd) begin
        int code;
        code = int'(bus_nib);
        m_phase = 0; m_k = 0; m_sleep = 0; q.delete();
        if (code == 1 && !m_cfg && chain_in) m_phase = 1;
        else if (code == 2 && m_cfg) m_phase = 2;
        else if (code == 3 && !m_cfg && chain_in) m_phase = 3;
        else if (code == 4 && m_cfg) m_phase = 4;
        else if (code == 5) begin m_cfg = 0; m_base = 0; m_lrst = 1; end
        else if (code == 6) m_sleep = 1;
        else if (code == 7 && m_cfg && dev_sel) m_dgo = 1;
      end else if (bus_strobe) begin
        if (m_phase == 1 || m_phase == 2) begin
          q.push_back(bus_nib);
          if (q.size() == 5) begin
            int v;
            v = 0;
            for (int i = 4; i >= 0; i--) v = v * 16 + int'(q[i]);
            if (m_phase == 1) begin m_cfg = 1; m_base = v; end
            else if (v == m_base) begin m_cfg = 0; m_base = 0; end
            m_phase = 0;
            q.delete();
          end
        end else if (m_phase == 3) begin
          m_k++;
          if (m_k == 5) m_phase = 0;
        end else if (m_phase == 4) begin
          m_phase = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the reference every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_en, e_nib;
      e_en = 0; e_nib = 0;
      if (m_phase == 3) begin e_en = 1; e_nib = int'((ID_VAL >> (4 * m_k)) & 20'hF); end
      if (m_phase == 4) begin e_en = 1; e_nib = svc_req ? (1 << PBIT) : 0; end
      chk(configured == m_cfg, "R2 configured", int'(configured), int'(m_cfg));
      chk(int'(base_addr) == m_base, "R4 base_addr", int'(base_addr), m_base);
      chk(chain_out == (m_cfg && chain_in), "R6 chain_out", int'(chain_out), int'(m_cfg && chain_in));
      chk(int'(resp_en) == e_en, "R7 resp_en", int'(resp_en), e_en);
      chk(int'(resp_nib) == e_nib, "R8 resp_nib", int'(resp_nib), e_nib);
      chk(local_rst == m_lrst, "R9 local_rst", int'(local_rst), int'(m_lrst));
      chk(dev_go == m_dgo, "R10 dev_go", int'(dev_go), int'(m_dgo));
      chk(sleep == m_sleep, "R11 sleep", int'(sleep), int'(m_sleep));
    end
  end

  task automatic xfer(input bit is_cmd, input logic [3:0] n);
    #1;
    bus_strobe = 1'b1; bus_cmd = is_cmd; bus_nib = n;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    #1;
    bus_strobe = 1'b0; bus_cmd = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_addr(input logic [19:0] a);
    for (int i = 0; i < 5; i++) xfer(1'b0, a[4*i +: 4]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, checked during reset
    chk(!configured && base_addr == 0 && !chain_out && !resp_en && resp_nib == 0 &&
        !local_rst && !dev_go && !sleep, "R1 reset state", int'(configured), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R2 configure refused while chain_in is low
    chain_in = 1'b0;
    xfer(1'b1, 4'd1); send_addr(20'h12345); idle(1);
    chk(!configured, "R2 refused without chain_in", int'(configured), 0);

    // R2 configure accepted
    #1 chain_in = 1'b1;
    xfer(1'b1, 4'd1);
    xfer(1'b0, 4'h1); xfer(1'b0, 4'hA); xfer(1'b0, 4'h5); xfer(1'b0, 4'hC);
    chk(!configured, "R2 not yet configured after four nibbles", int'(configured), 0);
    xfer(1'b0, 4'h3);
    chk(configured && base_addr == 20'h3C5A1, "R2 base captured", int'(base_addr), 'h3C5A1);
    idle(1);

    // R6 chain follows input once configured
    #1 chain_in = 1'b0; @(negedge clk);
    chk(!chain_out, "R6 chain_out low with chain_in low", int'(chain_out), 0);
    #1 chain_in = 1'b1; @(negedge clk);
    chk(chain_out, "R6 chain_out follows", int'(chain_out), 1);

    // R3 configured device ignores configure and identify
    xfer(1'b1, 4'd3);
    chk(!resp_en, "R3 no ID response when configured", int'(resp_en), 0);
    xfer(1'b1, 4'd1); send_addr(20'hFFFFF); idle(1);
    chk(base_addr == 20'h3C5A1, "R3 base kept", int'(base_addr), 'h3C5A1);

    // R8 poll
    #1 svc_req = 1'b1;
    xfer(1'b1, 4'd4);
    chk(resp_en && resp_nib == 4'b0100, "R8 poll bit set", int'(resp_nib), 4);
    xfer(1'b0, 4'd0);
    chk(!resp_en, "R8 poll ends at next strobe", int'(resp_en), 0);
    #1 svc_req = 1'b0;
    xfer(1'b1, 4'd4);
    chk(resp_en && resp_nib == 4'b0000, "R8 poll bit clear", int'(resp_nib), 0);
    idle(1);

    // R10 device command
    #1 dev_sel = 1'b0;
    xfer(1'b1, 4'd7);
    chk(!dev_go, "R10 no pulse when not selected", int'(dev_go), 0);
    #1 dev_sel = 1'b1;
    xfer(1'b1, 4'd7);
    chk(dev_go, "R10 pulse when selected", int'(dev_go), 1);
    idle(1);
    chk(!dev_go, "R10 pulse is one cycle", int'(dev_go), 0);

    // R11 shutdown then a no-op clears it
    xfer(1'b1, 4'd6); idle(2);
    chk(sleep, "R11 sleep held", int'(sleep), 1);
    xfer(1'b1, 4'd0);
    chk(!sleep, "R11 sleep cleared by next command", int'(sleep), 0);

    // R12 data after no-op and reserved codes, and strobe-low cycles
    send_addr(20'h00000);
    xfer(1'b1, 4'd8); send_addr(20'h00000);
    xfer(1'b1, 4'd9); send_addr(20'h00000);
    xfer(1'b1, 4'd13); send_addr(20'h00000);
    #1 bus_strobe = 1'b0; bus_cmd = 1'b1; bus_nib = 4'd5; @(negedge clk);
    chk(configured && base_addr == 20'h3C5A1, "R12 ignored traffic", int'(base_addr), 'h3C5A1);

    // R4 unconfigure with wrong then matching address
    xfer(1'b1, 4'd2); send_addr(20'h3C5A0); idle(1);
    chk(configured, "R4 mismatch keeps config", int'(configured), 1);
    xfer(1'b1, 4'd2); send_addr(20'h3C5A1); idle(1);
    chk(!configured && base_addr == 0, "R4 released", int'(configured), 0);
    chk(!chain_out, "R6 chain low after release", int'(chain_out), 0);

    // R8 no poll answer when unconfigured
    xfer(1'b1, 4'd4);
    chk(!resp_en, "R8 no poll when unconfigured", int'(resp_en), 0);

    // R7 and R5 identify again after release
    xfer(1'b1, 4'd3);
    for (int k = 0; k < 5; k++) begin
      chk(resp_en && resp_nib == ID_VAL[4*k +: 4], "R7 ID nibble", int'(resp_nib), int'(ID_VAL[4*k +: 4]));
      xfer(1'b0, 4'd0);
    end
    chk(!resp_en, "R7 ID ends after five", int'(resp_en), 0);

    // R12 abort mid-sequence
    xfer(1'b1, 4'd1); xfer(1'b0, 4'h7); xfer(1'b0, 4'h7);
    xfer(1'b1, 4'd0); send_addr(20'h99999); idle(1);
    chk(!configured, "R12 aborted configure", int'(configured), 0);

    // R5 reconfigure
    xfer(1'b1, 4'd1); send_addr(20'hABCDE); idle(1);
    chk(configured && base_addr == 20'hABCDE, "R5 reconfigured", int'(base_addr), 'hABCDE);

    // R9 bus reset, also abandoning a sequence
    xfer(1'b1, 4'd2); xfer(1'b0, 4'hE);
    xfer(1'b1, 4'd5);
    chk(local_rst && !configured && base_addr == 0, "R9 reset clears", int'(configured), 0);
    idle(1);
    chk(!local_rst, "R9 pulse one cycle", int'(local_rst), 0);
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule